// File: doc/BRIEF.md
# Asynchronous Static Memory Model

This block is a synthesizable behavioural model of a 2048-word by 8-bit static memory whose control pins carry no clock: an active-low select, an active-low read drive and an active-low write strobe, with an 11-bit address. The bidirectional data pin is split into a data input, a data output and a drive flag. A board-level bus model can use it in place of an external memory part. The data output is meant to be merged onto a shared bus only while the drive flag is high.

A free-running sampling clock, much faster than any pin activity, registers the select, the write strobe, the address and the input data. A write lasts for as long as the sampled select and the sampled strobe are both low. The model does not write on every low sample. It keeps the address and data seen on the last sample of that overlap and commits them to the array once, when the overlap ends. The overlap can end because the strobe rises or because the select rises.

The read path is combinational from the pins, so read data tracks the address without waiting for a clock. A standby flag shows when the part is deselected. The model ignores analog timing and nanosecond delays. It keeps only the order of events.

Top module: `async_sram_model`

## Requirements
- R1: The array holds 2048 independent 8-bit words, selected by the 11-bit `addr`. A word written at one address is read back unchanged, and writes to other addresses do not disturb it.
- R2: A write happens only when a clock edge samples `ce_n` low and `we_n` low together. Holding `we_n` low while `ce_n` is high changes no word.
- R3: `dout_oe` is 1 exactly when `ce_n` is 0, `oe_n` is 0 and `we_n` is 1, taken directly from the pins with no clock delay. In every other combination, including any time during a write, it is 0 and `dout` reads as zero.
- R4: While `dout_oe` is 1, `dout` equals the stored word at the current `addr`, and it follows a change of `addr` with no clock delay.
- R5: The word committed is the `din` captured on the last clock edge that sampled the overlap. A `din` change sampled on the same edge that first sees the overlap end is ignored. The new value can be read from the second rising clock edge after the terminating pin change onward.
- R6: A write ended by `ce_n` rising, with `we_n` still low, commits in the same way as one ended by `we_n` rising.
- R7: When `ce_n` and `we_n` rise together, the write still commits and `dout_oe` stays 0 throughout.
- R8: `standby` is 1 after reset and whenever the last clock edge sampled `ce_n` high. It drops to 0 at the first edge that samples `ce_n` low.
- R9: When the address changes in the middle of an overlap, only the address sampled on the last overlap edge is written. Earlier addresses of the same overlap keep their old contents.
- R10: Asynchronous active-low `rst_n` clears any partly captured write, so that no commit follows reset, and sets `standby` to 1. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than any pin activity |
| rst_n | input | 1 | Asynchronous active-low reset of the sampling logic |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 11 | Word address |
| din | input | 8 | Write data, the inbound half of the data pin |
| dout | output | 8 | Read data, the outbound half of the data pin; zero when not driving |
| dout_oe | output | 1 | High when the model drives the data pin |
| standby | output | 1 | High while the part is deselected |

## Verification
A corrupted capture register or overlap flag stays hidden until a read. It then shows up two edges after the write ends, as a wrong word at the written address or as a changed word at an address that was never the final one. A spurious commit can be spotted only by reading the address it damaged. For that reason the bench reads back neighbouring and aborted addresses as well as the target. A fault in the drive rule shows on `dout_oe` immediately, with no clock involved. A fault in the select sampler shows on `standby` one edge after `ce_n` moves.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
  localparam int unsigned DEF_ADDR_W = 11;
  localparam int unsigned DEF_DATA_W = 8;

  typedef struct packed {
    logic ce_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output strobe_t           smp_strobe,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [DATA_W-1:0] smp_din
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_strobe <= STROBE_IDLE;
      smp_addr   <= '0;
      smp_din    <= '0;
    end else begin
      smp_strobe <= '{ce_n: ce_n, we_n: we_n};
      smp_addr   <= addr;
      smp_din    <= din;
    end
  end
endmodule

// File: rtl/sram_write_capture.sv
module sram_write_capture
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           smp_strobe,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [DATA_W-1:0] smp_din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  logic overlap_now;
  logic overlap_seen;

  assign overlap_now = !smp_strobe.ce_n && !smp_strobe.we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overlap_seen <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
    end else begin
      overlap_seen <= overlap_now;
      if (overlap_now) begin
        commit_addr <= smp_addr;
        commit_data <= smp_din;
      end
    end
  end

  assign commit = overlap_seen && !overlap_now;
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              standby
);
  strobe_t           smp_strobe;
  logic [ADDR_W-1:0] smp_addr;
  logic [DATA_W-1:0] smp_din;
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;

  sram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .addr       (addr),
    .din        (din),
    .smp_strobe (smp_strobe),
    .smp_addr   (smp_addr),
    .smp_din    (smp_din)
  );

  sram_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_strobe  (smp_strobe),
    .smp_addr    (smp_addr),
    .smp_din     (smp_din),
    .commit      (wr_fire),
    .commit_addr (wr_addr),
    .commit_data (wr_data)
  );

  sram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_word)
  );

  assign dout_oe = !ce_n && !oe_n && we_n;
  assign dout    = dout_oe ? rd_word : '0;
  assign standby = smp_strobe.ce_n;
endmodule

// File: rtl/sram_model_checker.sv
module sram_model_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic dout_oe,
  input logic standby,
  input logic wr_fire
);
  a_r3_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_oe);

  a_r3_float_during_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_oe);

  a_r8_standby_set: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> standby);

  a_r8_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |=> !standby);

  a_r2_commit_needs_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ($past(ce_n, 2) == 1'b0 && $past(we_n, 2) == 1'b0));

  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

bind async_sram_model sram_model_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .we_n    (we_n),
  .dout_oe (dout_oe),
  .standby (standby),
  .wr_fire (wr_fire)
);

// File: tb/async_sram_model_tb_top.sv
module async_sram_model_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NVEC = 8;
  localparam int WATCHDOG = 20000;

  // each vector is {address, data}
  localparam logic [AW+DW-1:0] VEC [NVEC] = '{
    {11'd0,    8'hA5}, {11'd2047, 8'h5A}, {11'd1,    8'h01},
    {11'd1024, 8'hFF}, {11'd1023, 8'h00}, {11'd300,  8'h3C},
    {11'd777,  8'hC3}, {11'd5,    8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe, standby;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  async_sram_model dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .standby(standby)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // strobe-ended (mode 0), select-ended (mode 1) or both rising (mode 2)
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (mode == 0) we_n = 1'b1;
    else if (mode == 1) ce_n = 1'b1;
    else begin ce_n = 1'b1; we_n = 1'b1; end
    din = ~d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 q = dout;
  endtask

  initial begin
    logic [DW-1:0] q;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 standby in reset", standby, 1);
    chk("R3 no drive in reset", dout_oe, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 standby after reset", standby, 1);

    // vector table: write all, then read all
    for (int i = 0; i < NVEC; i++) wr(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], i % 3);
    for (int i = 0; i < NVEC; i++) begin
      rd(VEC[i][AW+DW-1:DW], q);
      chk("R1 readback of vector", q, VEC[i][DW-1:0]);
    end
    idle();

    // R4: address follows with no clock delay
    @(negedge clk);
    addr = 11'd0; ce_n = 0; oe_n = 0; we_n = 1;
    #1 chk("R4 read addr 0", dout, 8'hA5);
    #1 addr = 11'd2047;
    #1 chk("R4 read follows addr", dout, 8'h5A);
    chk("R3 read drives", dout_oe, 1);
    idle();

    // R3: all pin combinations (scratch address 100)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      addr = 11'd100; din = 8'h11;
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      #1 chk("R3 drive rule", dout_oe, (!c[2] && !c[1] && c[0]));
    end
    idle();

    // R2: strobe low while deselected writes nothing
    wr(11'd200, 8'h77, 0);
    @(negedge clk);
    addr = 11'd200; din = 8'h99; ce_n = 1; we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1;
    repeat (2) @(negedge clk);
    rd(11'd200, q);
    chk("R2 no write when deselected", q, 8'h77);
    idle();

    // R5: din change on terminating edge ignored; timing of visibility
    wr(11'd400, 8'h10, 0);
    @(negedge clk);
    addr = 11'd400; din = 8'h4E; ce_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk);
    #1 chk("R3 no drive during write", dout_oe, 0);
    @(negedge clk);
    we_n = 1; din = 8'hE4;
    #1 chk("R5 old word right after end", dout, 8'h10);
    @(negedge clk); #1;
    chk("R5 not yet committed after one edge", dout, 8'h10);
    @(negedge clk); #1;
    chk("R5 committed after second edge", dout, 8'h4E);
    idle();

    // R6: select-ended write
    wr(11'd500, 8'h6B, 1);
    rd(11'd500, q);
    chk("R6 select-ended commit", q, 8'h6B);
    idle();

    // R7: both rise together
    @(negedge clk);
    addr = 11'd600; din = 8'h7C; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    ce_n = 1; we_n = 1;
    #1 chk("R7 float on joint rise", dout_oe, 0);
    @(negedge clk); #1 chk("R7 still floating", dout_oe, 0);
    repeat (2) @(negedge clk);
    rd(11'd600, q);
    chk("R7 joint-rise commit", q, 8'h7C);
    idle();

    // R9: address change mid-overlap
    wr(11'd700, 8'h21, 0);
    wr(11'd701, 8'h22, 0);
    @(negedge clk);
    addr = 11'd700; din = 8'hAB; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    addr = 11'd701; din = 8'hCD;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1;
    repeat (3) @(negedge clk);
    rd(11'd700, q);
    chk("R9 earlier address untouched", q, 8'h21);
    rd(11'd701, q);
    chk("R9 final address written", q, 8'hCD);
    idle();

    // R8: standby timing
    @(negedge clk); #1 chk("R8 standby while deselected", standby, 1);
    ce_n = 0;
    #1 chk("R8 standby before sampling", standby, 1);
    @(negedge clk); #1 chk("R8 standby cleared", standby, 0);
    ce_n = 1;
    @(negedge clk); #1 chk("R8 standby set again", standby, 1);

    // R10: reset during overlap discards the write
    wr(11'd900, 8'h5E, 0);
    @(negedge clk);
    addr = 11'd900; din = 8'hE5; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 0; ce_n = 1; we_n = 1;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rd(11'd900, q);
    chk("R10 no commit after reset", q, 8'h5E);
    rd(11'd2047, q);
    chk("R10 array kept over reset", q, 8'h5A);
    idle();

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule